// File: doc/BRIEF.md
# Systolic Pipelined Incrementer

The block adds a single carry-in bit to an N-bit operand with a carry that moves forward by exactly one bit position per pipeline row. Every row contains one half-adder. It joins the carry arriving on its own lane with the operand bit on the next lane up. The sum bits that earlier rows have already produced travel on the lanes below. The operand bits that later rows still need travel on the lanes above. Each row registers its whole lane vector. Bits that belong to the same operand therefore stay aligned as they move down the array, and a new operand can enter on every clock whatever the width.

A grouping parameter lets several neighbouring rows share one register stage. The rows inside a group are chained combinationally. Only the last row of each group, and always the final row, is registered. The latency is the number of groups. This gives fewer registers in exchange for a longer carry path per stage. A one-bit valid tag travels through a delay line with the same number of stages, so it stays aligned with its result. A synchronous, active-high clear empties the whole pipeline.

Top module: `pipe_incrementer`

## Requirements
- R1: `{cout, sum_out}` equals `op_in + cin`, with the 9-bit result for the default width of 8. It appears exactly LAT = ceil(WIDTH / ROWS_PER_STAGE) rising edges after the operand is applied, which is WIDTH edges when fully pipelined.
- R2: A new operand and carry-in are accepted on every clock edge. Back-to-back operands produce back-to-back results with no interference between them.
- R3: `cout` is 1 only when the operand is all ones and `cin` is 1. In that cycle `sum_out` is all zeros.
- R4: `vld_out` equals the `vld_in` value applied LAT edges earlier, in the same cycle as the matching result.
- R5: A clock edge with `clr` high zeroes every pipeline register. Operands in flight at that edge, and the operand applied with it, are discarded. `sum_out`, `cout` and `vld_out` stay 0 until a new operand has travelled the full latency.
- R6: With ROWS_PER_STAGE set above 1, the latency shrinks to ceil(WIDTH / ROWS_PER_STAGE) while R1 to R4 still hold.
- R7: With `cin` = 0 the operand appears unchanged at `sum_out` with `cout` = 0. With `cin` = 1 and a zero operand, `sum_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all pipeline registers |
| clr | input | 1 | Synchronous active-high clear of the whole pipeline |
| vld_in | input | 1 | Tag travelling with the operand |
| op_in | input | WIDTH | Operand to be incremented |
| cin | input | 1 | Bit added to the operand |
| sum_out | output | WIDTH | Low WIDTH bits of the result |
| cout | output | 1 | Carry out of the most significant bit |
| vld_out | output | 1 | Tag aligned with `sum_out` and `cout` |

## Verification
Two functions of this block can fall in the same cycle. One is the clear. The other is a stream of tagged operands still in flight, or a tagged operand applied on the very clock where `clr` is high. The bench provokes this by streaming valid operands back to back and raising `clr` halfway through the stream, with `vld_in` high on that cycle. Afterwards it expects zero outputs and a low tag for the full latency, and only then the results of operands applied after the clear. The same scenario runs against a fully pipelined instance and a grouped instance, so the discard window is judged at two different latencies.

// File: rtl/pipe_inc_pkg.sv
package pipe_inc_pkg;

  // Number of register stages when rows are grouped g at a time.
  function automatic int stage_count(input int n, input int g);
    return (n + g - 1) / g;
  endfunction

  // A row is registered at the end of each group and always at the bottom.
  function automatic bit row_registered(input int i, input int n, input int g);
    return (((i + 1) % g) == 0) || (i == n - 1);
  endfunction

endpackage

// File: rtl/inc_row.sv
module inc_row #(
  parameter int N   = 8,
  parameter int IDX = 0,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [N:0]   lane_in,
  output logic [N:0]   lane_out
);

  logic [N:0] nxt;

  // Half-adder on lanes IDX (carry) and IDX+1 (operand bit); other lanes pass.
  always_comb begin
    nxt          = lane_in;
    nxt[IDX]     = lane_in[IDX] ^ lane_in[IDX+1];
    nxt[IDX+1]   = lane_in[IDX] & lane_in[IDX+1];
  end

  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (clr) lane_out <= '0;
        else     lane_out <= nxt;
      end
    end else begin : g_comb
      assign lane_out = nxt;
    end
  endgenerate

endmodule

// File: rtl/inc_tag_delay.sv
module inc_tag_delay #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic tag_in,
  output logic tag_out
);

  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (clr) sr <= '0;
        else     sr <= tag_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (clr) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], tag_in};
      end
    end
  endgenerate

  assign tag_out = sr[DEPTH-1];

endmodule

// File: rtl/pipe_incrementer.sv
module pipe_incrementer
  import pipe_inc_pkg::*;
#(
  parameter int WIDTH          = 8,
  parameter int ROWS_PER_STAGE = 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             vld_in,
  input  logic [WIDTH-1:0] op_in,
  input  logic             cin,
  output logic [WIDTH-1:0] sum_out,
  output logic             cout,
  output logic             vld_out
);

  localparam int LAT = stage_count(WIDTH, ROWS_PER_STAGE);
  localparam int CW  = $clog2(LAT + 1) + 1;

  // lanes[i] is the lane vector entering row i; lane 0 starts as the carry.
  logic [WIDTH:0] lanes [0:WIDTH];

  assign lanes[0] = {op_in, cin};

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_row
      inc_row #(
        .N   (WIDTH),
        .IDX (i),
        .REG (row_registered(i, WIDTH, ROWS_PER_STAGE))
      ) u_row (
        .clk      (clk),
        .clr      (clr),
        .lane_in  (lanes[i]),
        .lane_out (lanes[i+1])
      );
    end
  endgenerate

  assign sum_out = lanes[WIDTH][WIDTH-1:0];
  assign cout    = lanes[WIDTH][WIDTH];

  inc_tag_delay #(.DEPTH(LAT)) u_tag (
    .clk     (clk),
    .clr     (clr),
    .tag_in  (vld_in),
    .tag_out (vld_out)
  );

  // Cycles since the last clear, saturating at LAT (used by checks only).
  logic [CW-1:0] since_clr;
  always_ff @(posedge clk) begin
    if (clr)                          since_clr <= '0;
    else if (since_clr < CW'(LAT))    since_clr <= since_clr + 1'b1;
  end

  // R5: a clear edge leaves all outputs at zero.
  assert_clear_zeroes_R5: assert property (@(posedge clk)
    clr |=> (sum_out == '0) && !cout && !vld_out);

  // R5 / R4: no tag may emerge before a full latency has passed since a clear.
  assert_tag_quiet_after_clear_R5: assert property (@(posedge clk) disable iff (clr)
    (since_clr < CW'(LAT)) |-> !vld_out);

  // R5: a carry-out cannot emerge before an operand has crossed the array.
  assert_cout_after_fill_R5: assert property (@(posedge clk) disable iff (clr)
    cout |-> (since_clr >= CW'(LAT)));

  // R3: an overflowing increment always wraps the sum to zero.
  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (clr)
    cout |-> (sum_out == '0));

endmodule

// File: tb/tb_pipe_incrementer.sv
module tb_pipe_incrementer;

  localparam int W    = 8;
  localparam int G2   = 3;
  localparam int LAT1 = W;
  localparam int LAT2 = (W + G2 - 1) / G2;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         vld_in = 1'b0;
  logic [W-1:0] op_in = '0;
  logic         cin = 1'b0;

  logic [W-1:0] sum1, sum2;
  logic         cout1, cout2, vld1, vld2;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Expected {vld, cout, sum}, index LAT-1 is the oldest.
  logic [W+1:0] q1 [0:LAT1-1];
  logic [W+1:0] q2 [0:LAT2-1];

  always #5 clk = ~clk;

  pipe_incrementer #(.WIDTH(W), .ROWS_PER_STAGE(1)) dut (
    .clk(clk), .clr(clr), .vld_in(vld_in), .op_in(op_in), .cin(cin),
    .sum_out(sum1), .cout(cout1), .vld_out(vld1)
  );

  pipe_incrementer #(.WIDTH(W), .ROWS_PER_STAGE(G2)) dut_grp (
    .clk(clk), .clr(clr), .vld_in(vld_in), .op_in(op_in), .cin(cin),
    .sum_out(sum2), .cout(cout2), .vld_out(vld2)
  );

  task automatic chk(input string tag, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {vld,cout,sum}=%h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: compare both outputs at the falling edge, then drive new inputs.
  task automatic step(input string tag, input logic c, input logic v,
                      input logic [W-1:0] op, input logic ci);
    logic [W:0] r;
    @(negedge clk);
    chk(tag, {vld1, cout1, sum1}, q1[LAT1-1]);
    chk({tag, " R6"}, {vld2, cout2, sum2}, q2[LAT2-1]);
    for (int k = LAT1 - 1; k > 0; k--) q1[k] = q1[k-1];
    for (int k = LAT2 - 1; k > 0; k--) q2[k] = q2[k-1];
    r = {1'b0, op} + {{W{1'b0}}, ci};
    q1[0] = {v, r};
    q2[0] = {v, r};
    if (c) begin
      for (int k = 0; k < LAT1; k++) q1[k] = '0;
      for (int k = 0; k < LAT2; k++) q2[k] = '0;
    end
    clr = c; vld_in = v; op_in = op; cin = ci;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < LAT1 + 1; k++) step(tag, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic test_reset;
    for (int k = 0; k < 3; k++) step("R5 reset", 1'b1, 1'b1, 8'hFF, 1'b1);
    drain("R5 reset idle");
  endtask

  task automatic test_simple;
    step("R7", 1'b0, 1'b1, 8'h00, 1'b1);
    step("R7", 1'b0, 1'b1, 8'h5A, 1'b0);
    step("R7", 1'b0, 1'b1, 8'hA5, 1'b0);
    step("R7", 1'b0, 1'b1, 8'h0F, 1'b1);
    drain("R7 R1");
  endtask

  task automatic test_stream;
    for (int k = 0; k < 200; k++)
      step("R1 R2", 1'b0, 1'b1, W'($urandom), 1'($urandom));
    drain("R1 R2");
  endtask

  task automatic test_overflow;
    step("R3", 1'b0, 1'b1, 8'hFF, 1'b1);
    step("R3", 1'b0, 1'b1, 8'hFF, 1'b0);
    step("R3", 1'b0, 1'b1, 8'hFE, 1'b1);
    step("R3", 1'b0, 1'b1, 8'hFF, 1'b1);
    step("R3", 1'b0, 1'b1, 8'h7F, 1'b1);
    drain("R3");
  endtask

  task automatic test_valid_gaps;
    for (int k = 0; k < 40; k++)
      step("R4", 1'b0, 1'(k % 3 != 1), W'($urandom), 1'($urandom));
    drain("R4");
  endtask

  task automatic test_clear_midflight;
    for (int k = 0; k < 5; k++)
      step("R5 flight", 1'b0, 1'b1, W'($urandom), 1'b1);
    step("R5 flight", 1'b1, 1'b1, 8'hFF, 1'b1);
    for (int k = 0; k < 12; k++)
      step("R5 after", 1'b0, 1'b1, W'($urandom), 1'($urandom));
    drain("R5 after");
  endtask

  initial begin
    for (int k = 0; k < LAT1; k++) q1[k] = '0;
    for (int k = 0; k < LAT2; k++) q2[k] = '0;
    test_reset();
    test_simple();
    test_stream();
    test_overflow();
    test_valid_gaps();
    test_clear_midflight();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule